// File: doc/BRIEF.md
# Gamma-corrected binary code modulator

This block drives nine LED channels, grouped as three red/green/blue triples, with binary code modulation. A brightness write port takes one 8-bit value per channel. Each value goes through a square-law gamma curve to give a 12-bit intensity. The twelve intensity bits are then played out as bit-planes, one after another. Each plane is held on the output port for a time that matches the weight of its bit. After the heaviest plane comes a short all-dark slot, and then the next frame starts without outside help.

Writes first land in a pending set of brightness registers. The whole pending set is copied to the displayed set in one step at a frame boundary, so a frame never mixes old and new values. The output port is ten bits wide. Channels 0 to 7 drive bits 0 to 7, channel 8 drives bit 9, and bit 8 is a spare pin that is never driven high.

Top module: `bcm_gamma_driver`

## Requirements
- R1: A write with `wr_en` high stores `wr_val` as the pending brightness of channel `wr_ch` when `wr_ch` is 0 to 8. A write that names channel 9 to 15 is ignored and changes no output in any later frame.
- R2: Pending values are copied to the displayed set only on the clock edge that ends a frame. A write made in the last cycle of a frame takes that same edge, so it first appears one frame later. A write made one cycle earlier appears in the very next frame.
- R3: The displayed 12-bit level is (v × v) >> 4 for an 8-bit value v. So v = 0 keeps the channel dark for the whole frame, and v = 255 gives level 4064.
- R4: While plane j is shown, the output bit of channel i equals bit j of channel i's displayed level.
- R5: Planes run from bit 0 to bit 11. Plane j lasts 2^(j+1) clock cycles, so plane 0 lasts 2 cycles and plane 11 lasts 4096. Plane j starts at cycle 2^(j+1) − 2 of the frame.
- R6: After plane 11, all outputs are low for 2 cycles. The frame is 8192 cycles long, and the next frame begins at once with plane 0.
- R7: Channel c drives port bit c for c < 8, and channel 8 drives port bit 9. Port bit 8 is always low.
- R8: A synchronous active-high `rst` clears the pending and displayed values to zero and drives every output low. The first cycle after reset is cycle 0 of a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Brightness write strobe |
| wr_ch | input | 4 | Channel index of the write |
| wr_val | input | 8 | Brightness value to write |
| led_out | output | 10 | LED drive port with a fixed pin map |

## Verification
A brightness write and the swap of the displayed set can land on the same clock edge, and this is the case that matters. The bench writes in the last cycle of a frame and again in the cycle before it. It expects the earlier write to appear in the next frame, and the boundary write only in the frame after that. A reset in the middle of a frame also competes with the plane sequencer. The bench judges that case by requiring dark outputs and a frame count that restarts from zero. All checks come from a cycle-accurate model in the bench, with random writes mixed in.

// File: rtl/bcm_gamma_driver.sv
module bcm_gamma_driver #(
  parameter int CHANNELS  = 9,
  parameter int VAL_W     = 8,
  parameter int DEPTH     = 12,
  parameter int BLANK_LEN = 2,
  parameter int SKIP_PIN  = 8,
  parameter int CH_W      = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [CH_W-1:0]       wr_ch,
  input  logic [VAL_W-1:0]      wr_val,
  output logic [CHANNELS:0]     led_out
);
  localparam int PORT_W  = CHANNELS + 1;
  localparam int PROD_W  = 2 * VAL_W;
  localparam int PLANE_W = $clog2(DEPTH + 1);
  localparam int CNT_W   = DEPTH + 1;

  logic [VAL_W-1:0]   pend  [CHANNELS];
  logic [DEPTH-1:0]   level [CHANNELS];
  logic [PLANE_W-1:0] plane;
  logic [CNT_W-1:0]   cnt;
  logic [CNT_W-1:0]   hold_last;
  logic               slot_end, blank, frame_end;

  function automatic logic [DEPTH-1:0] gamma(input logic [VAL_W-1:0] v);
    logic [PROD_W-1:0] p;
    p = PROD_W'(v) * PROD_W'(v);
    return p[PROD_W-1 -: DEPTH];
  endfunction

  assign blank     = (plane == PLANE_W'(DEPTH));
  assign hold_last = blank ? CNT_W'(BLANK_LEN - 1)
                           : (CNT_W'(2) << plane) - CNT_W'(1);
  assign slot_end  = (cnt == hold_last);
  assign frame_end = slot_end && blank;

  always_ff @(posedge clk) begin
    if (rst) begin
      plane <= '0;
      cnt   <= '0;
      for (int c = 0; c < CHANNELS; c++) begin
        pend[c]  <= '0;
        level[c] <= '0;
      end
    end else begin
      cnt <= slot_end ? '0 : cnt + CNT_W'(1);
      if (slot_end)
        plane <= blank ? '0 : plane + PLANE_W'(1);
      if (frame_end)
        for (int c = 0; c < CHANNELS; c++)
          level[c] <= gamma(pend[c]);
      if (wr_en && (int'(wr_ch) < CHANNELS))
        pend[wr_ch] <= wr_val;
    end
  end

  for (genvar p = 0; p < PORT_W; p++) begin : g_pin
    if (p == SKIP_PIN) begin : g_spare
      assign led_out[p] = 1'b0;
    end else begin : g_drive
      localparam int CH = (p < SKIP_PIN) ? p : p - 1;
      assign led_out[p] = !blank && level[CH][plane];
    end
  end
endmodule

module bcm_gamma_checker #(
  parameter int CHANNELS  = 9,
  parameter int DEPTH     = 12,
  parameter int BLANK_LEN = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [CHANNELS:0] led_out
);
  localparam int FRAME = (1 << (DEPTH + 1)) - 2 + BLANK_LEN;
  localparam int POS_W = DEPTH + 2;

  logic [POS_W-1:0] pos;
  logic             start_next, at_blank;

  always_ff @(posedge clk)
    if (rst || pos == POS_W'(FRAME - 1)) pos <= '0;
    else                                 pos <= pos + POS_W'(1);

  function automatic logic is_start(input logic [POS_W-1:0] q);
    logic [POS_W-1:0] a;
    a = q + POS_W'(2);
    return (q == '0) || ((a & (a - POS_W'(1))) == '0);
  endfunction

  assign start_next = is_start((pos == POS_W'(FRAME - 1)) ? '0 : pos + POS_W'(1));
  assign at_blank   = (pos >= POS_W'(FRAME - BLANK_LEN));

  a_r5_hold_plane: assert property (@(posedge clk) disable iff (rst)
    !is_start(pos) |-> $stable(led_out));

  a_r2_write_no_glitch: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !start_next) |=> $stable(led_out));

  a_r6_blank_dark: assert property (@(posedge clk) disable iff (rst)
    at_blank |-> (led_out == '0));

  a_r8_reset_dark: assert property (@(posedge clk)
    rst |=> (led_out == '0));
endmodule

bind bcm_gamma_driver bcm_gamma_checker #(
  .CHANNELS(CHANNELS), .DEPTH(DEPTH), .BLANK_LEN(BLANK_LEN)
) i_checker (
  .clk(clk), .rst(rst), .wr_en(wr_en), .led_out(led_out)
);

// File: tb/test_bcm_gamma_driver.sv
`timescale 1ns/1ps
module test_bcm_gamma_driver;
  localparam int FRAME = 8192;
  localparam int NCH   = 9;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [3:0] wr_ch = '0;
  logic [7:0] wr_val = '0;
  logic [9:0] led_out;

  always #2 clk = ~clk;

  bcm_gamma_driver i_bcm_gamma_driver (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_ch(wr_ch),
    .wr_val(wr_val), .led_out(led_out)
  );

  int checks = 0;
  int errors = 0;
  int pend [NCH];
  int shown [NCH];
  int k = 0;
  int pos, fr, rst_left;
  bit mid_done = 0;
  string tag;

  function automatic int gamma(int v);
    return (v * v) >> 4;
  endfunction

  function automatic int plane_of(int p);
    for (int j = 0; j < 12; j++)
      if (p < (1 << (j + 2)) - 2) return j;
    return 12;
  endfunction

  function automatic logic [9:0] expect_out(int p);
    logic [9:0] e = '0;
    int pl = plane_of(p);
    if (pl == 12) return e;
    for (int c = 0; c < NCH; c++)
      e[c < 8 ? c : 9] = 1'((shown[c] >> pl) & 1);
    return e;
  endfunction

  function automatic bit plane_edge(int p);
    int a = p + 2;
    int b = p + 3;
    return ((a & (a - 1)) == 0) || ((b & (b - 1)) == 0);
  endfunction

  task automatic check(string t, logic [9:0] act, logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at cycle %0d: led_out=%b expected=%b", t, k, act, exp);
    end
  endtask

  task automatic model_reset();
    k = 0;
    for (int c = 0; c < NCH; c++) begin
      pend[c] = 0;
      shown[c] = 0;
    end
  endtask

  initial begin
    #800000;
    errors++;
    checks++;
    $display("FAIL watchdog: run did not end, led_out=%b expected=done", led_out);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_left = 0;
    repeat (3) @(posedge clk);
    model_reset();
    @(negedge clk);
    check("R8 reset state", led_out, 10'b0);
    rst = 1'b0;
    @(posedge clk);
    k = 1;
    forever begin
      @(negedge clk);
      pos = k % FRAME;
      fr  = k / FRAME;
      if (mid_done)                 tag = "R8";
      else if (pos >= FRAME - 2)    tag = "R6";
      else if (plane_edge(pos))     tag = "R5";
      else if (fr == 1)             tag = "R3";
      else if (fr == 5)             tag = "R1";
      else if (fr == 7 || fr == 8)  tag = "R2";
      else                          tag = "R4";
      check(tag, led_out, expect_out(pos));
      if (pos % 256 == 0) check("R7 spare pin", {9'b0, led_out[8]}, 10'b0);
      if (mid_done && k >= 2 * FRAME + 50) break;

      wr_en = 1'b0;
      rst   = 1'b0;
      if (!mid_done) begin
        if (fr == 0 && pos >= 10 && pos <= 13) begin
          wr_en = 1'b1;
          wr_ch = 4'(pos - 10);
          case (pos)
            10: wr_val = 8'd255;
            11: wr_val = 8'd0;
            12: wr_val = 8'd63;
            default: wr_val = 8'd200;
          endcase
        end else if (fr == 0 && pos >= 20 && pos <= 24) begin
          wr_en = 1'b1; wr_ch = 4'(pos - 16); wr_val = 8'($urandom_range(255, 0));
        end else if ((fr == 2 || fr == 3 || fr == 8) && $urandom_range(299, 0) == 0) begin
          wr_en = 1'b1; wr_ch = 4'($urandom_range(8, 0)); wr_val = 8'($urandom_range(255, 0));
        end else if (fr == 4 && pos >= 100 && pos <= 106) begin
          wr_en = 1'b1; wr_ch = 4'(pos - 91); wr_val = 8'd255;
        end else if (fr == 6 && pos == FRAME - 2) begin
          wr_en = 1'b1; wr_ch = 4'd6; wr_val = 8'd255;
        end else if (fr == 6 && pos == FRAME - 1) begin
          wr_en = 1'b1; wr_ch = 4'd5; wr_val = 8'd255;
        end
        if (fr == 9 && pos == 3000) begin
          rst_left = 3;
          mid_done = 1;
        end
      end
      if (rst_left > 0) begin
        rst = 1'b1;
        rst_left--;
      end

      @(posedge clk);
      if (rst) model_reset();
      else begin
        if (pos == FRAME - 1)
          for (int c = 0; c < NCH; c++) shown[c] = gamma(pend[c]);
        if (wr_en && wr_ch < 4'd9) pend[wr_ch] = int'(wr_val);
        k++;
      end
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule